// File: doc/BRIEF.md
# GPIO and Control Register Block

This block is a 16-bit register file on a plain word-addressed bus with separate read and write strobes. Alongside a set of general control registers it carries a 16-line general-purpose port, whose output pins follow the stored level wherever the matching direction bit is one. Bus writes to the port registers are masked by direction. Changes on the input pins are folded into the same level register.

Software writes a direction mask, then writes the level value. The output pins take the new value on the next clock. Input pin edges change the stored level at once, but they reach the output pins only at the next direction or level write. The read-only status register always returns its fixed code. A write to the power register that sets its trigger bit also sets two companion bits.

The block has no state machine. Every register is a plain load-enabled flop group, and read data comes out of a single registered multiplexer.

Top module: `ctl_gpio_regs`

## Requirements
- R1: The plain read/write registers return, one cycle after a read, the low 16 bits last written to them. Their byte offsets (low 6 address bits) are: mode 0x00, data 0x04, control 0x10, interrupt request 0x14, interrupt mask 0x18, interrupt status 0x1C, direction 0x20.
- R2: After reset, status reads 0x0002, every other register reads 0x0000 and `gpio_out` is 0x0000.
- R3: Status (offset 0x08) ignores writes and always reads 0x0002.
- R4: A write to power (offset 0x0C) stores the low 16 data bits. If data bit 7 is one, bits 15 and 6 are also set (value OR 0x8040).
- R5: A write to offset 0x24 or offset 0x28 stores the data ANDed with the current direction register into one shared level register, and both offsets read that register.
- R6: In the cycle after a write to direction or level, `gpio_out` equals the new level ANDed with the new direction.
- R7: A change on an input pin sets or clears its own level bit on the next clock edge, and it leaves `gpio_out` unchanged until the next direction or level write.
- R8: When a level write and an input change happen in the same cycle, the written value wins and the input change is dropped.
- R9: A read of an undecoded offset returns 0x0000. A write to one changes no register and no output.
- R10: Read data is registered and valid one cycle after the read strobe. It is 0x0000 in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rdata | output | 16 | Registered read data |
| gpio_in | input | 16 | Input pins that update the level register |
| gpio_out | output | 16 | Direction-masked level pins |

## Verification
Every result of this block is due exactly one clock edge after its stimulus: read data, register updates and the output pins. The bench therefore drives inputs on the falling edge, lets its reference model step on the rising edge, and compares `bus_rdata` and `gpio_out` on the next falling edge. The R7 check holds the input pins changed for several cycles with no port write, to show that the pins stay put while the stored level moves. The R8 check changes an input and writes the level in the same falling-edge slot.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

    localparam int REG_W = 16;
    localparam int OFF_W = 6;

    // byte offsets of the decoded registers
    localparam logic [OFF_W-1:0] OFF_MODE = 6'h00;
    localparam logic [OFF_W-1:0] OFF_DATA = 6'h04;
    localparam logic [OFF_W-1:0] OFF_STAT = 6'h08;
    localparam logic [OFF_W-1:0] OFF_PWR  = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_CTRL = 6'h10;
    localparam logic [OFF_W-1:0] OFF_IREQ = 6'h14;
    localparam logic [OFF_W-1:0] OFF_IMSK = 6'h18;
    localparam logic [OFF_W-1:0] OFF_ISTA = 6'h1C;
    localparam logic [OFF_W-1:0] OFF_DIR  = 6'h20;
    localparam logic [OFF_W-1:0] OFF_LVLW = 6'h24;
    localparam logic [OFF_W-1:0] OFF_LVLR = 6'h28;

    localparam logic [REG_W-1:0] STAT_CODE  = 16'h0002;
    localparam int               PWR_TRIG   = 7;
    localparam logic [REG_W-1:0] PWR_FORCE  = 16'h8040;

    // plain read/write registers held in one generic file
    localparam int PLAIN_N = 6;
    localparam int PIX_MODE = 0;
    localparam int PIX_DATA = 1;
    localparam int PIX_CTRL = 2;
    localparam int PIX_IREQ = 3;
    localparam int PIX_IMSK = 4;
    localparam int PIX_ISTA = 5;

    typedef enum logic [3:0] {
        SEL_MODE, SEL_DATA, SEL_STAT, SEL_PWR,
        SEL_CTRL, SEL_IREQ, SEL_IMSK, SEL_ISTA,
        SEL_DIR,  SEL_LVLW, SEL_LVLR, SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/cgr_addr_decode.sv
module cgr_addr_decode
    import cgr_pkg::*;
(
    input  logic [OFF_W-1:0] addr,
    output reg_sel_e         sel
);

    always_comb begin
        case (addr)
            OFF_MODE: sel = SEL_MODE;
            OFF_DATA: sel = SEL_DATA;
            OFF_STAT: sel = SEL_STAT;
            OFF_PWR:  sel = SEL_PWR;
            OFF_CTRL: sel = SEL_CTRL;
            OFF_IREQ: sel = SEL_IREQ;
            OFF_IMSK: sel = SEL_IMSK;
            OFF_ISTA: sel = SEL_ISTA;
            OFF_DIR:  sel = SEL_DIR;
            OFF_LVLW: sel = SEL_LVLW;
            OFF_LVLR: sel = SEL_LVLR;
            default:  sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/cgr_plain_regs.sv
module cgr_plain_regs #(
    parameter int W = 16,
    parameter int N = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      we,
    input  logic [W-1:0]      wdata,
    output logic [N-1:0][W-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= '0;
            else if (we[i])
                q[i] <= wdata;
        end
    end

endmodule

// File: rtl/cgr_power_reg.sv
module cgr_power_reg
    import cgr_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] store_val;

    always_comb begin
        store_val = wdata;
        if (wdata[PWR_TRIG])
            store_val = wdata | W'(PWR_FORCE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= store_val;
    end

endmodule

// File: rtl/cgr_gpio_port.sv
module cgr_gpio_port #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_we,
    input  logic         lvl_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lvl_q,
    output logic [W-1:0] pin_out
);

    logic [W-1:0] in_seen;
    logic [W-1:0] in_edge;
    logic [W-1:0] lvl_from_pins;
    logic [W-1:0] lvl_d;
    logic [W-1:0] dir_d;

    assign in_edge       = pin_in ^ in_seen;
    assign lvl_from_pins = (lvl_q & ~in_edge) | (pin_in & in_edge);
    assign lvl_d         = lvl_we ? (wdata & dir_q) : lvl_from_pins;
    assign dir_d         = dir_we ? wdata : dir_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_seen <= '0;
            lvl_q   <= '0;
            dir_q   <= '0;
            pin_out <= '0;
        end else begin
            in_seen <= pin_in;
            lvl_q   <= lvl_d;
            dir_q   <= dir_d;
            if (dir_we || lvl_we)
                pin_out <= lvl_d & dir_d;
        end
    end

endmodule

// File: rtl/ctl_gpio_regs.sv
module ctl_gpio_regs
    import cgr_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OFF_W-1:0]   bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [REG_W-1:0]   gpio_in,
    output logic [REG_W-1:0]   gpio_out
);

    reg_sel_e                   sel;
    logic [REG_W-1:0]           wval;
    logic                       unused_wdata_hi;
    logic [PLAIN_N-1:0]         plain_we;
    logic [PLAIN_N-1:0][REG_W-1:0] plain_q;
    logic [REG_W-1:0]           pwr_q;
    logic [REG_W-1:0]           dir_q;
    logic [REG_W-1:0]           lvl_q;
    logic [REG_W-1:0]           rd_mux;

    assign wval            = bus_wdata[REG_W-1:0];
    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:REG_W];

    cgr_addr_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb begin
        plain_we = '0;
        if (bus_wr) begin
            case (sel)
                SEL_MODE: plain_we[PIX_MODE] = 1'b1;
                SEL_DATA: plain_we[PIX_DATA] = 1'b1;
                SEL_CTRL: plain_we[PIX_CTRL] = 1'b1;
                SEL_IREQ: plain_we[PIX_IREQ] = 1'b1;
                SEL_IMSK: plain_we[PIX_IMSK] = 1'b1;
                SEL_ISTA: plain_we[PIX_ISTA] = 1'b1;
                default:  plain_we = '0;
            endcase
        end
    end

    cgr_plain_regs #(.W(REG_W), .N(PLAIN_N)) u_plain (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (plain_we),
        .wdata (wval),
        .q     (plain_q)
    );

    cgr_power_reg #(.W(REG_W)) u_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && sel == SEL_PWR),
        .wdata (wval),
        .q     (pwr_q)
    );

    cgr_gpio_port #(.W(REG_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_we  (bus_wr && sel == SEL_DIR),
        .lvl_we  (bus_wr && (sel == SEL_LVLW || sel == SEL_LVLR)),
        .wdata   (wval),
        .pin_in  (gpio_in),
        .dir_q   (dir_q),
        .lvl_q   (lvl_q),
        .pin_out (gpio_out)
    );

    always_comb begin
        case (sel)
            SEL_MODE: rd_mux = plain_q[PIX_MODE];
            SEL_DATA: rd_mux = plain_q[PIX_DATA];
            SEL_STAT: rd_mux = STAT_CODE;
            SEL_PWR:  rd_mux = pwr_q;
            SEL_CTRL: rd_mux = plain_q[PIX_CTRL];
            SEL_IREQ: rd_mux = plain_q[PIX_IREQ];
            SEL_IMSK: rd_mux = plain_q[PIX_IMSK];
            SEL_ISTA: rd_mux = plain_q[PIX_ISTA];
            SEL_DIR:  rd_mux = dir_q;
            SEL_LVLW: rd_mux = lvl_q;
            SEL_LVLR: rd_mux = lvl_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
        else
            bus_rdata <= '0;
    end

endmodule

// File: rtl/cgr_checker.sv
module cgr_checker
    import cgr_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OFF_W-1:0] bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [REG_W-1:0] bus_rdata,
    input logic [REG_W-1:0] gpio_out,
    input logic [REG_W-1:0] lvl_q,
    input logic [REG_W-1:0] dir_q,
    input logic [REG_W-1:0] pwr_q
);

    logic port_wr;
    logic lvl_wr;
    logic decoded;

    assign lvl_wr  = bus_wr && (bus_addr == OFF_LVLW || bus_addr == OFF_LVLR);
    assign port_wr = lvl_wr || (bus_wr && bus_addr == OFF_DIR);
    assign decoded = bus_addr == OFF_MODE || bus_addr == OFF_DATA || bus_addr == OFF_STAT ||
                     bus_addr == OFF_PWR  || bus_addr == OFF_CTRL || bus_addr == OFF_IREQ ||
                     bus_addr == OFF_IMSK || bus_addr == OFF_ISTA || bus_addr == OFF_DIR  ||
                     bus_addr == OFF_LVLW || bus_addr == OFF_LVLR;

    // R3
    status_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_STAT) |=> bus_rdata == STAT_CODE);

    // R4
    power_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_PWR && bus_wdata[PWR_TRIG]) |=> (pwr_q[15] && pwr_q[6]));

    // R5
    level_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_wr |=> (lvl_q & ~dir_q) == '0);

    // R6
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> gpio_out == (lvl_q & dir_q));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(gpio_out));

    // R9
    undecoded_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !decoded) |=> bus_rdata == '0);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

endmodule

bind ctl_gpio_regs cgr_checker #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpio_out  (gpio_out),
    .lvl_q     (lvl_q),
    .dir_q     (dir_q),
    .pwr_q     (pwr_q)
);

// File: tb/tb_ctl_gpio_regs.sv
`timescale 1ns/1ps
module tb_ctl_gpio_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] gpio_in = '0;
    logic [15:0] gpio_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctl_gpio_regs dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gpio_in   (gpio_in),
        .gpio_out  (gpio_out)
    );

    // behavioural reference model, indexed by offset/4
    int    m_reg [0:15];
    int    m_dir, m_lvl, m_out, m_seen, m_rdata;
    string m_tag = "R10";
    bit    m_live = 1'b0;

    function automatic bit is_decoded(int a);
        return (a % 4 == 0) && (a <= 'h28);
    endfunction

    function automatic string tag_of(int a);
        if (!is_decoded(a)) return "R9";
        if (a == 'h08) return "R3";
        if (a == 'h0C) return "R4";
        if (a == 'h24 || a == 'h28) return "R5";
        return "R1";
    endfunction

    function automatic int model_read(int a);
        if (!is_decoded(a)) return 0;
        if (a == 'h08) return 2;
        if (a == 'h20) return m_dir;
        if (a == 'h24 || a == 'h28) return m_lvl;
        return m_reg[a/4];
    endfunction

    always @(posedge clk) begin
        int a, w, edge_m, nl, nd;
        if (!rst_n) begin
            foreach (m_reg[i]) m_reg[i] = 0;
            m_dir = 0; m_lvl = 0; m_out = 0; m_seen = 0; m_rdata = 0;
            m_tag = "R2";
            m_live = 1'b1;
        end else begin
            a = int'(bus_addr);
            w = int'(bus_wdata[15:0]);
            m_rdata = bus_rd ? model_read(a) : 0;
            m_tag   = bus_rd ? tag_of(a) : "R10";
            edge_m  = int'(gpio_in) ^ m_seen;
            nl      = (m_lvl & ~edge_m) | (int'(gpio_in) & edge_m);
            nd      = m_dir;
            m_seen  = int'(gpio_in);
            if (bus_wr && is_decoded(a)) begin
                if (a == 'h0C)
                    m_reg[3] = w[7] ? (w | 'h8040) : w;
                else if (a == 'h20)
                    nd = w;
                else if (a == 'h24 || a == 'h28)
                    nl = w & m_dir;
                else if (a != 'h08)
                    m_reg[a/4] = w;
                if (a == 'h20 || a == 'h24 || a == 'h28)
                    m_out = nl & nd;
            end
            m_lvl = nl;
            m_dir = nd;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (m_live && !done) begin
            check(m_tag, int'(bus_rdata), m_rdata);
            check("R6", int'(gpio_out), m_out);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = 6'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        bus_addr = 6'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = int'(bus_rdata);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5.0);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int v;
        int offs [11] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C, 'h20, 'h24, 'h28};
        int plain [7] = '{'h00, 'h04, 'h10, 'h14, 'h18, 'h1C, 'h20};
        int lf;

        idle(4);
        rst_n = 1'b1;

        // R2: reset values
        for (int i = 0; i < 11; i++) begin
            rd(offs[i], v);
            check("R2", v, (offs[i] == 'h08) ? 2 : 0);
        end
        check("R2", int'(gpio_out), 0);

        // R1: plain registers keep low 16 bits
        for (int i = 0; i < 7; i++) wr(plain[i], 'hABCD_1200 + i * 'h111);
        for (int i = 0; i < 7; i++) begin
            rd(plain[i], v);
            check("R1", v, ('h1200 + i * 'h111) & 'hFFFF);
        end

        // R3: status ignores writes
        wr('h08, 'hFFFF);
        rd('h08, v); check("R3", v, 'h0002);

        // R4: power side effect
        wr('h0C, 'h0080); rd('h0C, v); check("R4", v, 'h80C0);
        wr('h0C, 'h0001); rd('h0C, v); check("R4", v, 'h0001);
        wr('h0C, 'h1280); rd('h0C, v); check("R4", v, 'h92C0);

        // R5 / R6: masked level writes, aliased addresses
        wr('h20, 'h00FF);
        wr('h24, 'hFFFF);
        rd('h24, v); check("R5", v, 'h00FF);
        rd('h28, v); check("R5", v, 'h00FF);
        check("R6", int'(gpio_out), 'h00FF);
        wr('h28, 'h0F0F);
        rd('h24, v); check("R5", v, 'h000F);
        check("R6", int'(gpio_out), 'h000F);
        wr('h20, 'hF0F0);
        check("R6", int'(gpio_out), 'h0000);
        wr('h24, 'hFFFF);
        check("R6", int'(gpio_out), 'hF0F0);

        // R7: inputs move the level, not the pins
        wr('h20, 'hFFFF);
        wr('h24, 'h0000);
        @(negedge clk); gpio_in = 16'h0011;
        idle(3);
        check("R7", int'(gpio_out), 'h0000);
        rd('h28, v); check("R7", v, 'h0011);
        wr('h20, 'hFFFF);
        check("R7", int'(gpio_out), 'h0011);
        @(negedge clk); gpio_in = 16'h0001;
        idle(2);
        rd('h24, v); check("R7", v, 'h0001);
        check("R7", int'(gpio_out), 'h0011);

        // R8: same-cycle level write beats input edge
        @(negedge clk);
        gpio_in = 16'h0101;
        bus_addr = 6'h24; bus_wdata = 32'h00F0; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        idle(2);
        rd('h24, v); check("R8", v, 'h00F0);

        // R9: undecoded offsets
        rd('h00, lf);
        wr('h2C, 'hFFFF); wr('h01, 'hFFFF); wr('h3C, 'hFFFF);
        rd('h2C, v); check("R9", v, 0);
        rd('h3F, v); check("R9", v, 0);
        rd('h00, v); check("R9", v, lf);
        check("R9", int'(gpio_out), m_out);

        // R10: idle read data
        idle(2);
        check("R10", int'(bus_rdata), 0);

        // mixed traffic against the model
        lf = 'h1ACE;
        for (int i = 0; i < 300; i++) begin
            lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 'hFFFF;
            @(negedge clk);
            bus_wr    = lf[0];
            bus_rd    = lf[1];
            bus_addr  = lf[2] ? 6'(offs[(lf >> 3) % 11]) : 6'(lf >> 4);
            bus_wdata = {16'hDEAD, 16'(lf * 7)};
            if (lf[9]) gpio_in = 16'(lf ^ 'h5A5A);
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        idle(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule